// File: doc/BRIEF.md
# Three-Cycle Data Break Transfer Engine

This block moves a run of 12-bit words between main memory and a word-addressed disk store. The transfer is steered by two control words in main memory: a word count and a current address, each at a fixed location. For every word the engine first reads and increments the word count, then reads and increments the current address, and only then moves the data word. The run ends after the word for which the incremented count becomes zero. Software therefore loads the negated word count, and the address of the word just before the buffer.

A start strobe selects the direction and supplies the 17-bit starting disk address and the 3-bit memory field. The physical memory address is the field placed above the incremented 12-bit current address, so a buffer wraps inside its field. On disk writes, the top three disk address bits pick one of eight write-lock bits. A locked word is not stored and raises a sticky error flag. Memory writes aimed above the populated memory size are dropped silently. Words move either back to back (burst) or with a fixed idle gap between them.

When the run ends, the engine drops busy, sets done and pulses the interrupt. It also presents the updated 17-bit disk address, whose top five bits form the extension field. After a write run that address is one less than the sum of the starting address and the word count.

Top module: `dbk_engine`

## Requirements
- R1: Each word follows a fixed order of accesses, one memory access per clock: read the count word (physical 07750), write it back incremented, read the address word (physical 07751), write it back incremented, then the data cycle. A memory write and a disk write never happen in the same clock.
- R2: The count and address words are incremented modulo 4096 before the word moves. The run stops after the word whose incremented count is 0, which leaves the count word in memory at 0.
- R3: The data word's physical memory address is {field[2:0], incremented address[11:0]}. An address of 07777 wraps to 0000 in the same field.
- R4: With start_wr=0 (disk to memory), the disk word at the current disk address is written to the word's physical memory address.
- R5: With start_wr=1 (memory to disk), the memory word at the word's physical address is written to the disk store at the current disk address.
- R6: The disk address increments modulo 2^17 after every word. At the end of a read run it equals start_da+N. At the end of a write run it equals start_da+N-1. cur_da does not change while the engine is idle.
- R7: On a write, wlock[cur_da[16:14]]=1 blocks the disk store for that word and sets wl_err. Other words of the same run are still stored. wl_err stays set until the next accepted start.
- R8: A memory write to a physical address at or above MEM_WORDS is suppressed, and no error is flagged.
- R9: With burst=1 a run of N words takes 6N clocks. With burst=0 the engine idles GAP_CYCLES clocks between words, for 6N+GAP_CYCLES*(N-1) clocks.
- R10: At completion, busy falls, done rises and irq pulses for exactly one clock. An accepted start clears done and wl_err. A start while busy is ignored.
- R11: After reset, busy, done, irq and wl_err are 0, cur_da is 0, and no memory or disk write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted when idle |
| start_wr | input | 1 | Direction: 1 memory to disk, 0 disk to memory |
| start_da | input | 17 | Initial disk address |
| start_mex | input | 3 | Memory field for data words |
| burst | input | 1 | 1 back-to-back words, 0 gap between words |
| wlock | input | 8 | Write-lock bit per disk region |
| mem_addr | output | 15 | Physical memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one clock after the address |
| dsk_addr | output | 17 | Disk store address |
| dsk_we | output | 1 | Disk store write enable |
| dsk_wdata | output | 12 | Disk store write data |
| dsk_rdata | input | 12 | Disk store read data, one clock after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, sticky |
| irq | output | 1 | One-clock completion pulse |
| wl_err | output | 1 | Write-lock error, sticky |
| cur_da | output | 17 | Current or final disk address |

## Verification
The bench builds the engine with MEM_WORDS=4096, so only field 0 is populated and any nonzero field lands in nonexistent memory. A read run into field 1 then shows directly that the data writes are dropped while the count and address words still update. GAP_CYCLES=3 keeps the gap short, yet the non-burst run lengths still differ clearly from the burst ones. The remaining defaults are kept, so a write run that crosses disk address 0x14000 passes from lock region 4 into region 5. That crossing lets the same run contain both stored and blocked words.

// File: rtl/dbk_pkg.sv
`timescale 1ns/1ps
package dbk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_WC,
      ST_WR_WC,
      ST_RD_MA,
      ST_WR_MA,
      ST_XA,
      ST_XB,
      ST_GAP
   } dbk_state_e;
endpackage

// File: rtl/dbk_gap_timer.sv
`timescale 1ns/1ps
// Counts the idle interval between words in single-word mode.
module dbk_gap_timer #(
   parameter int GAP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (GAP_CYCLES == 0) begin : g_none
         assign expired = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(GAP_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (load)            cnt_q <= CW'(GAP_CYCLES - 1);
            else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
         end
         assign expired = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/dbk_disk_addr.sv
`timescale 1ns/1ps
// Disk address counter with region write-lock lookup.
module dbk_disk_addr #(
   parameter int DA_W      = 17,
   parameter int LOCK_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DA_W-1:0]      load_val,
   input  logic                 step,
   input  logic [LOCK_BITS-1:0] wlock,
   output logic [DA_W-1:0]      da,
   output logic                 locked
);
   localparam int IDX_W = (LOCK_BITS > 1) ? $clog2(LOCK_BITS) : 1;

   initial begin : p_param_chk
      if (LOCK_BITS > 1 && (1 << IDX_W) != LOCK_BITS)
         $fatal(1, "LOCK_BITS must be a power of two");
      if (IDX_W > DA_W)
         $fatal(1, "LOCK_BITS too large for DA_W");
   end

   logic [DA_W-1:0] da_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     da_q <= '0;
      else if (load)  da_q <= load_val;
      else if (step)  da_q <= da_q + DA_W'(1);
   end
   assign da = da_q;

   generate
      if (LOCK_BITS == 1) begin : g_single
         assign locked = wlock[0];
      end else begin : g_region
         assign locked = wlock[da_q[DA_W-1 -: IDX_W]];
      end
   endgenerate
endmodule

// File: rtl/dbk_seq.sv
`timescale 1ns/1ps
// Per-word access sequencer: count word, address word, then the data cycle.
module dbk_seq
   import dbk_pkg::*;
#(
   parameter int              WORD_W     = 12,
   parameter int              MEXT_W     = 3,
   parameter int              PA_W       = 15,
   parameter int              MEM_WORDS  = 32768,
   parameter int              GAP_CYCLES = 4,
   parameter logic [PA_W-1:0] WC_LOC     = '0,
   parameter logic [PA_W-1:0] MA_LOC     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic [MEXT_W-1:0] start_mex,
   input  logic              burst,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic [WORD_W-1:0] dsk_rdata,
   input  logic              locked,
   input  logic              gap_done,
   output logic [PA_W-1:0]   mem_addr,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              dsk_we,
   output logic [WORD_W-1:0] dsk_wdata,
   output logic              da_load,
   output logic              da_step,
   output logic              gap_load,
   output logic              busy,
   output logic              done,
   output logic              irq,
   output logic              wl_err
);
   localparam logic [PA_W:0] MEM_LIM = (PA_W+1)'(MEM_WORDS);

   dbk_state_e        state_q, state_d;
   logic              wr_q, burst_q;
   logic [MEXT_W-1:0] mex_q;
   logic [WORD_W-1:0] wc_q, ma_q;
   logic              done_q, irq_q, err_q;

   logic [PA_W-1:0]   pa;
   logic              pa_ok, last_word, accept;
   logic [WORD_W-1:0] rd_inc;

   assign pa        = {mex_q, ma_q};
   assign pa_ok     = ({1'b0, pa} < MEM_LIM);
   assign last_word = (wc_q == '0);
   assign accept    = (state_q == ST_IDLE) && start;
   assign rd_inc    = mem_rdata + WORD_W'(1);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_RD_WC;
         ST_RD_WC: state_d = ST_WR_WC;
         ST_WR_WC: state_d = ST_RD_MA;
         ST_RD_MA: state_d = ST_WR_MA;
         ST_WR_MA: state_d = ST_XA;
         ST_XA:    state_d = ST_XB;
         ST_XB: begin
            if (last_word)                          state_d = ST_IDLE;
            else if (burst_q || GAP_CYCLES == 0)    state_d = ST_RD_WC;
            else                                    state_d = ST_GAP;
         end
         ST_GAP:   if (gap_done) state_d = ST_RD_WC;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_addr  = WC_LOC;
      mem_we    = 1'b0;
      mem_wdata = rd_inc;
      dsk_we    = 1'b0;
      dsk_wdata = mem_rdata;
      unique case (state_q)
         ST_RD_WC: mem_addr = WC_LOC;
         ST_WR_WC: begin mem_addr = WC_LOC; mem_we = 1'b1; end
         ST_RD_MA: mem_addr = MA_LOC;
         ST_WR_MA: begin mem_addr = MA_LOC; mem_we = 1'b1; end
         ST_XA:    mem_addr = pa;
         ST_XB: begin
            mem_addr  = pa;
            mem_wdata = dsk_rdata;
            mem_we    = !wr_q && pa_ok;
            dsk_we    = wr_q && !locked;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         burst_q <= 1'b0;
         mex_q   <= '0;
         wc_q    <= '0;
         ma_q    <= '0;
         done_q  <= 1'b0;
         irq_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= 1'b0;
         if (accept) begin
            wr_q    <= start_wr;
            burst_q <= burst;
            mex_q   <= start_mex;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
         end
         if (state_q == ST_WR_WC) wc_q <= rd_inc;
         if (state_q == ST_WR_MA) ma_q <= rd_inc;
         if (state_q == ST_XB) begin
            if (wr_q && locked) err_q <= 1'b1;
            if (last_word) begin
               done_q <= 1'b1;
               irq_q  <= 1'b1;
            end
         end
      end
   end

   assign da_load  = accept;
   assign da_step  = (state_q == ST_XB) && !(last_word && wr_q);
   assign gap_load = (state_q == ST_XB) && !last_word && !burst_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign irq      = irq_q;
   assign wl_err   = err_q;
endmodule

// File: rtl/dbk_engine.sv
`timescale 1ns/1ps
module dbk_engine #(
   parameter int WORD_W     = 12,
   parameter int MEXT_W     = 3,
   parameter int DEXT_W     = 5,
   parameter int LOCK_BITS  = 8,
   parameter int MEM_WORDS  = 32768,
   parameter int GAP_CYCLES = 4,
   parameter int WC_LOC     = 'o7750,
   parameter int MA_LOC     = 'o7751
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     start_wr,
   input  logic [DEXT_W+WORD_W-1:0] start_da,
   input  logic [MEXT_W-1:0]        start_mex,
   input  logic                     burst,
   input  logic [LOCK_BITS-1:0]     wlock,
   output logic [MEXT_W+WORD_W-1:0] mem_addr,
   output logic                     mem_we,
   output logic [WORD_W-1:0]        mem_wdata,
   input  logic [WORD_W-1:0]        mem_rdata,
   output logic [DEXT_W+WORD_W-1:0] dsk_addr,
   output logic                     dsk_we,
   output logic [WORD_W-1:0]        dsk_wdata,
   input  logic [WORD_W-1:0]        dsk_rdata,
   output logic                     busy,
   output logic                     done,
   output logic                     irq,
   output logic                     wl_err,
   output logic [DEXT_W+WORD_W-1:0] cur_da
);
   localparam int PA_W = MEXT_W + WORD_W;
   localparam int DA_W = DEXT_W + WORD_W;

   initial begin : p_param_chk
      if (MEM_WORDS < 1 || MEM_WORDS > (1 << PA_W))
         $fatal(1, "MEM_WORDS out of range");
      if (WC_LOC >= MEM_WORDS || MA_LOC >= MEM_WORDS || WC_LOC == MA_LOC)
         $fatal(1, "control word locations invalid");
      if (GAP_CYCLES < 0)
         $fatal(1, "GAP_CYCLES negative");
   end

   logic            da_load, da_step, gap_load, gap_done, locked;
   logic [DA_W-1:0] da;

   dbk_seq #(
      .WORD_W    (WORD_W),
      .MEXT_W    (MEXT_W),
      .PA_W      (PA_W),
      .MEM_WORDS (MEM_WORDS),
      .GAP_CYCLES(GAP_CYCLES),
      .WC_LOC    (PA_W'(WC_LOC)),
      .MA_LOC    (PA_W'(MA_LOC))
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_wr (start_wr),
      .start_mex(start_mex),
      .burst    (burst),
      .mem_rdata(mem_rdata),
      .dsk_rdata(dsk_rdata),
      .locked   (locked),
      .gap_done (gap_done),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .dsk_we   (dsk_we),
      .dsk_wdata(dsk_wdata),
      .da_load  (da_load),
      .da_step  (da_step),
      .gap_load (gap_load),
      .busy     (busy),
      .done     (done),
      .irq      (irq),
      .wl_err   (wl_err)
   );

   dbk_disk_addr #(
      .DA_W     (DA_W),
      .LOCK_BITS(LOCK_BITS)
   ) u_da (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (da_load),
      .load_val(start_da),
      .step    (da_step),
      .wlock   (wlock),
      .da      (da),
      .locked  (locked)
   );

   dbk_gap_timer #(
      .GAP_CYCLES(GAP_CYCLES)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (gap_load),
      .expired(gap_done)
   );

   assign dsk_addr = da;
   assign cur_da   = da;
endmodule

// File: rtl/dbk_engine_chk.sv
`timescale 1ns/1ps
module dbk_engine_chk #(
   parameter int PA_W      = 15,
   parameter int DA_W      = 17,
   parameter int LOCK_BITS = 8,
   parameter int MEM_WORDS = 32768,
   parameter int WC_LOC    = 'o7750,
   parameter int MA_LOC    = 'o7751
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic                 irq,
   input logic                 mem_we,
   input logic [PA_W-1:0]      mem_addr,
   input logic                 dsk_we,
   input logic [DA_W-1:0]      dsk_addr,
   input logic [LOCK_BITS-1:0] wlock,
   input logic [DA_W-1:0]      cur_da
);
   localparam int IDX_W = (LOCK_BITS > 1) ? $clog2(LOCK_BITS) : 1;
   localparam logic [PA_W:0] LIM = (PA_W+1)'(MEM_WORDS);

   AST_NXM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, mem_addr} < LIM));  // R8
   AST_LOCKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      dsk_we |-> !wlock[dsk_addr[DA_W-1 -: IDX_W]]);  // R7
   AST_WC_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == PA_W'(WC_LOC)) |-> ($past(mem_addr) == PA_W'(WC_LOC) && !$past(mem_we) && busy));  // R1
   AST_MA_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == PA_W'(MA_LOC)) |-> ($past(mem_addr) == PA_W'(MA_LOC) && !$past(mem_we)));  // R1
   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && dsk_we));  // R1
   AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (irq && !busy));  // R10
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);  // R10
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);  // R10
   AST_IDLE_DA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(cur_da));  // R6
endmodule

bind dbk_engine dbk_engine_chk #(
   .PA_W     (PA_W),
   .DA_W     (DA_W),
   .LOCK_BITS(LOCK_BITS),
   .MEM_WORDS(MEM_WORDS),
   .WC_LOC   (WC_LOC),
   .MA_LOC   (MA_LOC)
) u_chk (.*);

// File: tb/dbk_engine_tb_top.sv
`timescale 1ns/1ps
module dbk_engine_tb_top;
   localparam int GAP = 3;
   localparam logic [11:0] WCA = 12'o7750;
   localparam logic [11:0] MAA = 12'o7751;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, start_wr = 1'b0, burst = 1'b0;
   logic [16:0] start_da = '0;
   logic [2:0]  start_mex = '0;
   logic [7:0]  wlock = '0;
   logic [14:0] mem_addr;
   logic        mem_we;
   logic [11:0] mem_wdata, mem_rdata;
   logic [16:0] dsk_addr;
   logic        dsk_we;
   logic [11:0] dsk_wdata, dsk_rdata;
   logic        busy, done, irq, wl_err;
   logic [16:0] cur_da;

   always #2.5 clk = ~clk;

   dbk_engine #(.MEM_WORDS(4096), .GAP_CYCLES(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
      .start_da(start_da), .start_mex(start_mex), .burst(burst), .wlock(wlock),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dsk_addr(dsk_addr), .dsk_we(dsk_we), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
      .busy(busy), .done(done), .irq(irq), .wl_err(wl_err), .cur_da(cur_da)
   );

   // Memory (field 0 only) and disk store models with write counters.
   logic [11:0] mem [4096];
   logic [11:0] dsk [4096];
   int n_mw = 0, n_dw = 0, n_nxm = 0, n_any = 0;
   logic [15:0] acc_log [8];
   int log_n = 0;

   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_addr[14:12] == 3'd0) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            n_mw <= n_mw + 1;
         end else n_nxm <= n_nxm + 1;
      end
      mem_rdata <= (mem_addr[14:12] == 3'd0) ? mem[mem_addr[11:0]] : 12'h000;
      if (dsk_we) begin
         dsk[dsk_addr[11:0]] <= dsk_wdata;
         n_dw <= n_dw + 1;
      end
      dsk_rdata <= dsk[dsk_addr[11:0]];
      if (mem_we || dsk_we) n_any <= n_any + 1;
      if (busy && log_n < 8) begin
         acc_log[log_n] <= {mem_we, mem_addr};
         log_n <= log_n + 1;
      end
   end

   function automatic logic [11:0] mpat(input logic [11:0] a);
      return 12'(a * 3 + 12'h055);
   endfunction
   function automatic logic [11:0] dpat(input logic [11:0] a);
      return 12'(a * 5 + 1);
   endfunction

   int checks = 0, errors = 0;
   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic        wr;
      logic        bst;
      logic [2:0]  mex;
      logic [7:0]  n;
      logic [11:0] ma0;
      logic [16:0] da0;
      logic [7:0]  lk;
      logic [16:0] exp_da;
      logic        exp_err;
      logic [7:0]  exp_dw;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 3'd0, 8'd4, 12'o0777, 17'h00040, 8'h00, 17'h00044, 1'b0, 8'd0},
      '{1'b0, 1'b0, 3'd0, 8'd3, 12'o2777, 17'h1FFFE, 8'h00, 17'h00001, 1'b0, 8'd0},
      '{1'b0, 1'b1, 3'd0, 8'd3, 12'o7776, 17'h03000, 8'h00, 17'h03003, 1'b0, 8'd0},
      '{1'b1, 1'b1, 3'd0, 8'd5, 12'o1777, 17'h00200, 8'h00, 17'h00204, 1'b0, 8'd5},
      '{1'b1, 1'b0, 3'd0, 8'd4, 12'o3777, 17'h13FFE, 8'h20, 17'h14001, 1'b1, 8'd2},
      '{1'b0, 1'b1, 3'd1, 8'd2, 12'o0100, 17'h00500, 8'h00, 17'h00502, 1'b0, 8'd0}
   };

   // Starts a run at the next edge and waits for busy to fall; returns busy length.
   task automatic launch(input vec_t v, output int cyc);
      @(negedge clk);
      mem[WCA] <= 12'(4096 - int'(v.n));
      mem[MAA] <= v.ma0;
      @(negedge clk);
      start = 1'b1; start_wr = v.wr; burst = v.bst;
      start_da = v.da0; start_mex = v.mex; wlock = v.lk;
      @(negedge clk);
      start = 1'b0;
      check(busy && !done && !wl_err, "R10 start clears done/err", {busy, done, wl_err}, 3'b100);
      cyc = 0;
      while (busy && cyc < 2000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : p_main
      int cyc, mw0, dw0, nx0, exp_cyc, exp_mw;
      for (int i = 0; i < 4096; i++) begin
         mem[i] <= mpat(12'(i));
         dsk[i] <= dpat(12'(i));
      end
      repeat (4) @(negedge clk);
      // R11: reset state
      check(!busy && !done && !irq && !wl_err, "R11 flags after reset", {busy, done, irq, wl_err}, 0);
      check(cur_da == 17'h0, "R11 cur_da after reset", cur_da, 0);
      check(n_any == 0, "R11 no writes in reset", n_any, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(n_any == 0 && !busy, "R11 idle after reset", n_any, 0);

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         v = VECS[k];
         mw0 = n_mw; dw0 = n_dw; nx0 = n_nxm;
         launch(v, cyc);
         exp_cyc = v.bst ? 6 * int'(v.n) : 6 * int'(v.n) + GAP * (int'(v.n) - 1);
         exp_mw  = 2 * int'(v.n) + ((!v.wr && v.mex == 3'd0) ? int'(v.n) : 0);
         check(cyc == exp_cyc, $sformatf("R9 run length v%0d", k), cyc, exp_cyc);
         check(cur_da == v.exp_da, $sformatf("R6 final disk addr v%0d", k), cur_da, v.exp_da);
         check(done && irq && !busy, $sformatf("R10 completion v%0d", k), {done, irq, busy}, 3'b110);
         check(wl_err == v.exp_err, $sformatf("R7 wl_err v%0d", k), wl_err, v.exp_err);
         check(mem[WCA] == 12'h000, $sformatf("R2 count word v%0d", k), mem[WCA], 0);
         check(mem[MAA] == 12'(v.ma0 + v.n), $sformatf("R2 R3 address word v%0d", k), mem[MAA], 12'(v.ma0 + v.n));
         check(n_dw - dw0 == int'(v.exp_dw), $sformatf("R5 R7 disk writes v%0d", k), n_dw - dw0, v.exp_dw);
         check(n_mw - mw0 == exp_mw, $sformatf("R1 R8 memory writes v%0d", k), n_mw - mw0, exp_mw);
         check(n_nxm == nx0, $sformatf("R8 nonexistent writes v%0d", k), n_nxm - nx0, 0);
         for (int w = 0; w < int'(v.n); w++) begin
            logic [11:0] ma;
            logic [16:0] da;
            ma = 12'(v.ma0 + 12'(w) + 12'd1);
            da = 17'(v.da0 + 17'(w));
            if (!v.wr && v.mex == 3'd0)
               check(mem[ma] == dpat(da[11:0]), $sformatf("R4 R3 read data v%0d w%0d", k, w), mem[ma], dpat(da[11:0]));
            else if (v.wr && !v.lk[da[16:14]])
               check(dsk[da[11:0]] == mpat(ma), $sformatf("R5 write data v%0d w%0d", k, w), dsk[da[11:0]], mpat(ma));
            else if (v.wr)
               check(dsk[da[11:0]] == dpat(da[11:0]), $sformatf("R7 locked word kept v%0d w%0d", k, w), dsk[da[11:0]], dpat(da[11:0]));
         end
         @(negedge clk);
         check(!irq && done, $sformatf("R10 irq one clock v%0d", k), {irq, done}, 2'b01);
         if (k == 0) begin
            // R1: access order of the first word of a read run
            check(acc_log[0] == {1'b0, 3'd0, WCA}, "R1 read count word", acc_log[0], {1'b0, 3'd0, WCA});
            check(acc_log[1] == {1'b1, 3'd0, WCA}, "R1 write count word", acc_log[1], {1'b1, 3'd0, WCA});
            check(acc_log[2] == {1'b0, 3'd0, MAA}, "R1 read address word", acc_log[2], {1'b0, 3'd0, MAA});
            check(acc_log[3] == {1'b1, 3'd0, MAA}, "R1 write address word", acc_log[3], {1'b1, 3'd0, MAA});
            check(acc_log[5] == {1'b1, 15'o01000}, "R1 R3 data write", acc_log[5], {1'b1, 15'o01000});
         end
      end

      // R10: a start while busy is ignored
      begin
         vec_t v;
         v = '{1'b0, 1'b1, 3'd0, 8'd2, 12'o4777, 17'h00600, 8'h00, 17'h00602, 1'b0, 8'd0};
         dw0 = n_dw;
         fork
            launch(v, cyc);
            begin
               repeat (5) @(negedge clk);
               start = 1'b1; start_wr = 1'b1; start_da = 17'h00700;
               @(negedge clk);
               start = 1'b0;
            end
         join
         check(cur_da == 17'h00602, "R10 start while busy ignored (addr)", cur_da, 17'h00602);
         check(cyc == 12 && n_dw == dw0, "R10 start while busy ignored (run)", cyc, 12);
      end

      // R6: idle disk address holds
      repeat (5) @(negedge clk);
      check(cur_da == 17'h00602 && !busy, "R6 idle cur_da stable", cur_da, 17'h00602);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule